// File: doc/BRIEF.md
# Paged-Register I2C Slave

This block is the control port of a configurable mixed-signal device. It is an I2C slave that sits in front of a register file organised as two pages of 128 byte-wide registers. A host reaches it over the two open-drain bus lines. Each line comes in as a sampled input and goes out as a pull-low enable, so the block never drives a line high. The block only answers. It never starts a transfer and never stretches the clock.

A write transfer carries a register address followed by any number of data bytes. A read transfer returns bytes starting at the current register pointer, and the usual way to set that pointer is a write that carries only an address, then a repeated START. Register address 0 does not hold data. On every page it is a shared page pointer. Writing it selects which page addresses 1 to 127 reach, and that choice stays in force for all later transfers until address 0 is written again. Reading address 0 returns the active page, so the host can confirm a page switch.

The bus lines pass through a two-flop synchronizer and are oversampled by the system clock. Every SCL high phase and every SCL low phase must therefore last at least four system clocks.

Top module: `pagedRegI2c`

## Requirements
- R1: The slave acknowledges only the address byte whose upper seven bits equal 0011000. That byte is 0x30 for a write and 0x31 for a read, with bit 0 set meaning read. For any other address it does not pull SDA low on the ninth clock, and it leaves the bus alone until the next START. No register changes in such a transfer.
- R2: A START is an SDA fall while SCL is high, and a STOP is an SDA rise while SCL is high. A repeated START aborts the transfer in progress and restarts address matching.
- R3: In a write transfer, the first byte after the address byte loads the register pointer from its low seven bits, and bit 7 is ignored. Every later byte is written to the register under the pointer. The slave acknowledges the address byte, the pointer byte and every data byte by pulling SDA low on the ninth clock.
- R4: Writing address 0 sets the active page from bit 0 of the data: 0x00 selects page 0 and 0x01 selects page 1. Addresses 1 to 127 then reach the registers of that page only. The same address on the two pages is separate storage, and the page choice persists across transfers.
- R5: Reading address 0 returns the active page zero-extended, 0x00 or 0x01.
- R6: A read transfer shifts out the byte under the pointer MSB first, driving each bit while SCL is low. A master ACK requests the next byte. After a master NACK the slave keeps SDA released.
- R7: The register pointer advances by one after every data byte written or read, and it wraps from 127 to 0. A burst that wraps therefore reaches the page register.
- R8: After reset every data register is 0x00, the active page is 0, the pointer is 0, and both pull-low enables are 0.
- R9: The SCL pull-low enable is always 0. The SDA pull-low enable changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Level sampled from the SCL line |
| sdaIn | input | 1 | Level sampled from the SDA line |
| sclPullLow | output | 1 | Pull-low enable for SCL, always 0 |
| sdaPullLow | output | 1 | Pull-low enable for SDA; 1 pulls the line low |

## Verification
Assertions check three things on every cycle. The SDA drive changes only while the synchronized SCL is low. The active page moves only on a data write while the pointer is 0. The pointer changes only on a load or an increment, and an increment adds exactly one modulo 128. The bench's bus transfers are the only way to show the rest: address matching and ignoring foreign addresses, that the two pages hold separate contents, readback of the page register, a burst that wraps into the page register, the reset contents, and the release of SDA after a master NACK.

// File: rtl/pagedRegI2cPkg.sv
package pagedRegI2cPkg;
  localparam int BYTE_W = 8;
  localparam int BUS_ADDR_W = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RX_DEV, ST_ACK_DEV, ST_RX_REG, ST_ACK_REG,
    ST_RX_DATA, ST_ACK_DATA, ST_TX_BYTE, ST_TX_ACK
  } busState_t;

  typedef struct packed {
    logic loadPtr;
    logic writeByte;
    logic incPtr;
  } regStrobe_t;
endpackage

// File: rtl/pagedRegSync.sv
module pagedRegSync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '1;
    end else begin
      stage[0] <= din;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/pagedRegI2cCtrl.sv
module pagedRegI2cCtrl
  import pagedRegI2cPkg::*;
#(
  parameter logic [BUS_ADDR_W-1:0] DEV_ADDR = 7'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclS,
  input  logic              sdaS,
  input  logic [BYTE_W-1:0] rdData,
  output regStrobe_t        strb,
  output logic [BYTE_W-1:0] wrByte,
  output logic              sdaLow
);
  busState_t state;
  logic [3:0] bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic sclD, sdaD, isRead, ackOk;
  logic sclRise, sclFall, startEv, stopEv, byteDone;

  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startEv  = sclS & sclD & sdaD & ~sdaS;
  assign stopEv   = sclS & sclD & ~sdaD & sdaS;
  assign byteDone = sclFall && (bitCnt == 4'd8);

  assign strb.loadPtr   = (state == ST_RX_REG) && byteDone;
  assign strb.writeByte = (state == ST_RX_DATA) && byteDone;
  assign strb.incPtr    = strb.writeByte || ((state == ST_TX_BYTE) && byteDone);
  assign wrByte = shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      bitCnt <= '0;
      shiftReg <= '0;
      sdaLow <= 1'b0;
      isRead <= 1'b0;
      ackOk <= 1'b0;
    end else if (startEv) begin
      state <= ST_RX_DEV;
      bitCnt <= '0;
      sdaLow <= 1'b0;
    end else if (stopEv) begin
      state <= ST_IDLE;
      sdaLow <= 1'b0;
    end else begin
      case (state)
        ST_RX_DEV, ST_RX_REG, ST_RX_DATA: begin
          if (sclRise && bitCnt < 4'd8) begin
            shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
            bitCnt <= bitCnt + 4'd1;
          end else if (byteDone) begin
            bitCnt <= '0;
            if (state == ST_RX_DEV) begin
              if (shiftReg[BYTE_W-1:1] == DEV_ADDR) begin
                sdaLow <= 1'b1;
                isRead <= shiftReg[0];
                state <= ST_ACK_DEV;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              sdaLow <= 1'b1;
              state <= (state == ST_RX_REG) ? ST_ACK_REG : ST_ACK_DATA;
            end
          end
        end
        ST_ACK_DEV: begin
          if (sclFall) begin
            if (isRead) begin
              shiftReg <= rdData;
              sdaLow <= ~rdData[BYTE_W-1];
              state <= ST_TX_BYTE;
            end else begin
              sdaLow <= 1'b0;
              state <= ST_RX_REG;
            end
          end
        end
        ST_ACK_REG, ST_ACK_DATA: begin
          if (sclFall) begin
            sdaLow <= 1'b0;
            state <= ST_RX_DATA;
          end
        end
        ST_TX_BYTE: begin
          if (sclRise && bitCnt < 4'd8) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (byteDone) begin
            bitCnt <= '0;
            sdaLow <= 1'b0;
            state <= ST_TX_ACK;
          end else if (sclFall) begin
            sdaLow <= ~shiftReg[BYTE_W-2];
            shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
          end
        end
        ST_TX_ACK: begin
          if (sclRise) begin
            ackOk <= ~sdaS;
          end else if (sclFall) begin
            if (ackOk) begin
              shiftReg <= rdData;
              sdaLow <= ~rdData[BYTE_W-1];
              state <= ST_TX_BYTE;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pagedRegBank.sv
module pagedRegBank
  import pagedRegI2cPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int PAGES = 2,
  localparam int REGS = 1 << ADDR_W,
  localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [BYTE_W-1:0] wrByte,
  output logic [BYTE_W-1:0] rdData,
  output logic [PAGE_W-1:0] activePage,
  output logic [ADDR_W-1:0] regPtr
);
  logic [BYTE_W-1:0] mem [PAGES][REGS];
  logic unusedBits;

  assign unusedBits = ^wrByte[BYTE_W-1:ADDR_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activePage <= '0;
      regPtr <= '0;
      for (int p = 0; p < PAGES; p++)
        for (int r = 0; r < REGS; r++)
          mem[p][r] <= '0;
    end else begin
      if (strb.writeByte) begin
        if (regPtr == '0) activePage <= wrByte[PAGE_W-1:0];
        else mem[activePage][regPtr] <= wrByte;
      end
      if (strb.loadPtr) regPtr <= wrByte[ADDR_W-1:0];
      else if (strb.incPtr) regPtr <= regPtr + 1'b1;
    end
  end

  always_comb begin
    if (regPtr == '0) rdData = {{(BYTE_W-PAGE_W){1'b0}}, activePage};
    else rdData = mem[activePage][regPtr];
  end
endmodule

// File: rtl/pagedRegI2c.sv
module pagedRegI2c
  import pagedRegI2cPkg::*;
#(
  parameter logic [BUS_ADDR_W-1:0] DEV_ADDR = 7'h18,
  parameter int ADDR_W = 7,
  parameter int PAGES = 2,
  parameter int SYNC_STAGES = 2,
  localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclPullLow,
  output logic sdaPullLow
);
  logic sclSync, sdaSync;
  regStrobe_t strb;
  logic [BYTE_W-1:0] wrByte, rdData;
  logic [PAGE_W-1:0] activePage;
  logic [ADDR_W-1:0] regPtr;

  pagedRegSync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .din({sclIn, sdaIn}), .dout({sclSync, sdaSync})
  );

  pagedRegI2cCtrl #(.DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclS(sclSync), .sdaS(sdaSync), .rdData(rdData),
    .strb(strb), .wrByte(wrByte), .sdaLow(sdaPullLow)
  );

  pagedRegBank #(.ADDR_W(ADDR_W), .PAGES(PAGES)) bank_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrByte(wrByte), .rdData(rdData),
    .activePage(activePage), .regPtr(regPtr)
  );

  assign sclPullLow = 1'b0;
endmodule

// File: rtl/pagedRegI2cChk.sv
module pagedRegI2cChk
  import pagedRegI2cPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclSync,
  input logic              sdaPullLow,
  input regStrobe_t        strb,
  input logic [PAGE_W-1:0] activePage,
  input logic [ADDR_W-1:0] regPtr
);
  assert_sda_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    $changed(sdaPullLow) |-> !$past(sclSync));

  assert_page_only_by_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    $changed(activePage) |-> $past(strb.writeByte && regPtr == '0));

  assert_ptr_step_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incPtr && !strb.loadPtr) |=> (regPtr == $past(regPtr) + 1'b1));

  assert_ptr_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    $changed(regPtr) |-> $past(strb.loadPtr || strb.incPtr));
endmodule

bind pagedRegI2c pagedRegI2cChk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) chk_i (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .sdaPullLow(sdaPullLow),
  .strb(strb), .activePage(activePage), .regPtr(regPtr)
);

// File: tb/pagedRegI2c_tb_top.sv
module pagedRegI2c_tb_top;
  localparam int Q = 8;
  localparam logic [7:0] DEV_W = 8'h30;
  localparam logic [7:0] DEV_R = 8'h31;
  // {page, register address, data}
  localparam logic [15:0] VEC [6] = '{
    {1'b0, 7'd1, 8'hA5}, {1'b1, 7'd1, 8'h5A}, {1'b0, 7'd64, 8'h3C},
    {1'b1, 7'd64, 8'hC3}, {1'b0, 7'd127, 8'h81}, {1'b1, 7'd2, 8'h7E}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mSclLow = 1'b0;
  logic mSdaLow = 1'b0;
  logic sclPullLow, sdaPullLow, sclLine, sdaLine;
  logic sclEverDriven = 1'b0;
  int errors = 0;
  int checks = 0;
  logic [7:0] wrBuf [4];
  logic [7:0] rdBuf [4];
  logic ackSeen;

  always #10 clk = ~clk;

  assign sclLine = !(mSclLow || sclPullLow);
  assign sdaLine = !(mSdaLow || sdaPullLow);

  pagedRegI2c dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow)
  );

  always @(negedge clk) if (sclPullLow) sclEverDriven <= 1'b1;

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic checkVal(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    mSdaLow = 1'b0; waitQ();
    mSclLow = 1'b0; waitQ();
    mSdaLow = 1'b1; waitQ();
    mSclLow = 1'b1; waitQ();
  endtask

  task automatic busStop();
    mSdaLow = 1'b1; waitQ();
    mSclLow = 1'b0; waitQ();
    mSdaLow = 1'b0; waitQ();
  endtask

  task automatic putBit(logic b);
    mSdaLow = !b; waitQ();
    mSclLow = 1'b0; waitQ(); waitQ();
    mSclLow = 1'b1; waitQ();
  endtask

  task automatic getBit(output logic b);
    mSdaLow = 1'b0; waitQ();
    mSclLow = 1'b0; waitQ();
    b = sdaLine; waitQ();
    mSclLow = 1'b1; waitQ();
  endtask

  task automatic sendByte(logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b);
    acked = !b;
  endtask

  task automatic recvByte(output logic [7:0] v, input logic ackIt);
    for (int i = 7; i >= 0; i--) getBit(v[i]);
    putBit(!ackIt);
  endtask

  task automatic writeRegs(logic [7:0] regAddr, int n, string tag);
    logic a;
    busStart();
    sendByte(DEV_W, a); checkVal({tag, " R1 address ack"}, a, 1);
    sendByte(regAddr, a); checkVal({tag, " R3 pointer ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(wrBuf[i], a); checkVal({tag, " R3 data ack"}, a, 1);
    end
    busStop();
  endtask

  task automatic readRegs(logic [7:0] regAddr, int n, string tag);
    logic a;
    busStart();
    sendByte(DEV_W, a); checkVal({tag, " R1 address ack"}, a, 1);
    sendByte(regAddr, a); checkVal({tag, " R3 pointer ack"}, a, 1);
    busStart();
    sendByte(DEV_R, a); checkVal({tag, " R2 restart ack"}, a, 1);
    for (int i = 0; i < n; i++) recvByte(rdBuf[i], i != n - 1);
    waitQ();
    checkVal({tag, " R6 SDA released after NACK"}, sdaPullLow, 0);
    busStop();
  endtask

  task automatic selectPage(logic [7:0] p);
    wrBuf[0] = p;
    writeRegs(8'h00, 1, "R4 select");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    checkVal("R8 sda idle in reset", sdaPullLow, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    checkVal("R8 sda idle after reset", sdaPullLow, 0);
    checkVal("R9 scl never pulled", sclPullLow, 0);

    readRegs(8'h00, 1, "R8");
    checkVal("R8 R5 page after reset", rdBuf[0], 8'h00);
    readRegs(8'h05, 1, "R8");
    checkVal("R8 register zero after reset", rdBuf[0], 8'h00);

    // R1: foreign address is ignored
    busStart();
    sendByte(8'h32, ackSeen); checkVal("R1 foreign address no ack", ackSeen, 0);
    sendByte(8'h03, ackSeen); checkVal("R1 silent after foreign", ackSeen, 0);
    sendByte(8'hAA, ackSeen); checkVal("R1 silent data", ackSeen, 0);
    busStop();
    readRegs(8'h03, 1, "R1");
    checkVal("R1 no write from foreign transfer", rdBuf[0], 8'h00);

    // R2: repeated START after a foreign address restarts matching
    busStart();
    sendByte(8'h34, ackSeen); checkVal("R2 foreign first", ackSeen, 0);
    busStart();
    sendByte(DEV_W, ackSeen); checkVal("R2 restart match", ackSeen, 1);
    sendByte(8'h09, ackSeen); checkVal("R2 pointer ack", ackSeen, 1);
    sendByte(8'h99, ackSeen); checkVal("R2 data ack", ackSeen, 1);
    busStop();
    readRegs(8'h09, 1, "R2");
    checkVal("R2 data after restart", rdBuf[0], 8'h99);

    // R4: table of page/address/data, written then read back
    for (int i = 0; i < 6; i++) begin
      selectPage({7'd0, VEC[i][15]});
      wrBuf[0] = VEC[i][7:0];
      writeRegs({1'b0, VEC[i][14:8]}, 1, "R4 table");
    end
    for (int i = 0; i < 6; i++) begin
      selectPage({7'd0, VEC[i][15]});
      readRegs({1'b0, VEC[i][14:8]}, 1, "R4 table");
      checkVal("R4 paged readback", rdBuf[0], VEC[i][7:0]);
    end

    // R5 and R4 persistence
    selectPage(8'h01);
    readRegs(8'h00, 1, "R5");
    checkVal("R5 page register reads 1", rdBuf[0], 8'h01);
    readRegs(8'h01, 1, "R4");
    checkVal("R4 page persists across transfers", rdBuf[0], 8'h5A);
    selectPage(8'h00);
    readRegs(8'h00, 1, "R5");
    checkVal("R5 page register reads 0", rdBuf[0], 8'h00);

    // R3: bit 7 of the pointer byte ignored
    wrBuf[0] = 8'h44;
    writeRegs(8'h85, 1, "R3");
    readRegs(8'h05, 1, "R3");
    checkVal("R3 pointer bit 7 ignored", rdBuf[0], 8'h44);

    // R7: write burst wrapping into the page register
    wrBuf[0] = 8'h11; wrBuf[1] = 8'h22; wrBuf[2] = 8'h01;
    writeRegs(8'h7E, 3, "R7");
    readRegs(8'h00, 1, "R7");
    checkVal("R7 wrap wrote page register", rdBuf[0], 8'h01);
    selectPage(8'h00);
    readRegs(8'h7E, 2, "R6");
    checkVal("R6 burst byte 0", rdBuf[0], 8'h11);
    checkVal("R6 burst byte 1", rdBuf[1], 8'h22);
    readRegs(8'h7F, 3, "R7");
    checkVal("R7 read 127", rdBuf[0], 8'h22);
    checkVal("R7 read wraps to page register", rdBuf[1], 8'h00);
    checkVal("R7 read continues at 1", rdBuf[2], 8'hA5);

    checkVal("R9 scl never pulled over run", sclEverDriven, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule